// File: doc/BRIEF.md
# Dual-Issue Pairing Decision

This block sits between a two-wide decode stage and the execution units of an in-order processor. Each cycle it sees the two oldest decoded instructions: slot 0 (older) and slot 1 (younger). It decides whether only slot 0 issues, or whether slot 1 issues alongside it. A pair issues together only when one instruction is floating-point and the other is integer or memory. Integer and floating-point work use separate register files, so an accepted pair never needs more read or write ports on either file. A memory instruction forms its address from the integer file even when it moves floating-point data, so memory always counts as the integer side of a pair.

The younger instruction is also held back when it touches a register that the older one writes in the same file. When slot 1 is held, the fetch side moves it into slot 0 for the next cycle and fills slot 1 with a new instruction. A stall from the downstream interlock freezes both slots.

The decision is purely combinational. The clock and reset only time the built-in checks. The issue outputs act as the ready side of two valid/ready slots. A slot whose instruction is valid and whose issue output is high is consumed in that cycle. A valid slot that is not consumed must be presented again, unchanged, on the next cycle, either in the same slot or, for a held slot 1, moved into slot 0. Stall is the only back-pressure input.

Top module: `dual_issue_pair`

## Requirements
- R1: `issue0` is high exactly when `slot0_valid` is high and `stall` is low.
- R2: While `stall` is high, `issue0`, `issue1` and `hold1` are all low, whatever the slot contents.
- R3: `issue1` is never high unless `issue0` is high in the same cycle, so issue stays in program order.
- R4: Class codes sit in bits [1:0] of each instruction word: 0 = integer, 1 = memory, 2 = floating-point. With no register conflict and no stall, and both slots valid, `issue1` is high only when one slot is class 2 and the other is class 0 or 1.
- R5: Class code 3 is reserved and never pairs with anything. Two slots of the same side (both integer/memory, or both floating-point) never pair.
- R6: Above the class bits, an instruction word holds three operand fields of RIDX_W+2 bits each: destination, then source A, then source B. Each field is {enable, fp_file, index}, with the index in the low bits. `issue1` is low when the slot 0 destination is enabled, and an enabled slot 1 operand (destination or either source) names the same file and the same index.
- R7: An operand whose enable bit is 0 never causes a conflict. This holds on both sides, whatever its index and file bits.
- R8: The same index in different files (fp_file bits unequal) is not a conflict.
- R9: `hold1` is high exactly when `slot1_valid` is high, `stall` is low and `issue1` is low.
- R10: When slot 0 is not valid, slot 1 does not issue, and a valid slot 1 is reported as held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the built-in checks |
| rst_n | input | 1 | Active-low reset; disables the checks |
| stall | input | 1 | Downstream interlock; freezes both slots |
| slot0_valid | input | 1 | Older instruction present |
| slot0_insn | input | INSN_W | Older decoded instruction word |
| slot1_valid | input | 1 | Younger instruction present |
| slot1_insn | input | INSN_W | Younger decoded instruction word |
| issue0 | output | 1 | Older instruction issues this cycle |
| issue1 | output | 1 | Younger instruction issues with it |
| hold1 | output | 1 | Younger instruction stays for the next cycle |

## Verification
The bench builds the block with RIDX_W = 2, which shrinks each operand field to a 4-bit code. With fields that small, the sweeps can be exhaustive. They cover all 16 class pairings and every combination of the two valid bits with stall. They also cover every slot 0 destination code against every code of each slot 1 operand, for both pairable class orders. Every same-index/different-file case, every disabled-operand case and every enabled match is therefore visited, alongside an operand word with several simultaneous matches.

// File: rtl/dual_pair_pkg.sv
`timescale 1ns/1ps
package dual_pair_pkg;

  typedef enum logic [1:0] {
    CLS_INT = 2'd0,
    CLS_MEM = 2'd1,
    CLS_FP  = 2'd2,
    CLS_RSV = 2'd3
  } insn_class_e;

  // Operand fields in an instruction word, lowest first.
  localparam int NUM_OPS = 3;
  localparam int CLS_W   = 2;

  // True for classes that use the integer register file for their reads.
  function automatic logic int_side(input logic [1:0] code);
    return (code == CLS_INT) || (code == CLS_MEM);
  endfunction

endpackage

// File: rtl/pair_class_chk.sv
`timescale 1ns/1ps
module pair_class_chk
  import dual_pair_pkg::*;
(
  input  logic [1:0] cls_old,
  input  logic [1:0] cls_young,
  output logic       mix_ok
);

  logic old_fp, young_fp;

  always_comb begin
    old_fp   = (cls_old   == CLS_FP);
    young_fp = (cls_young == CLS_FP);
    mix_ok   = (old_fp && int_side(cls_young)) ||
               (young_fp && int_side(cls_old));
  end

endmodule

// File: rtl/pair_dep_chk.sv
`timescale 1ns/1ps
module pair_dep_chk
  import dual_pair_pkg::*;
#(
  parameter int RIDX_W = 5,
  localparam int OPF_W = RIDX_W + 2
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [OPF_W-1:0]         old_dst,
  input  logic [NUM_OPS*OPF_W-1:0] young_ops,
  output logic                     conflict
);

  localparam int EN_BIT = RIDX_W + 1;
  localparam int FP_BIT = RIDX_W;

  logic [NUM_OPS-1:0] hit;

  generate
    for (genvar k = 0; k < NUM_OPS; k++) begin : g_op
      logic [OPF_W-1:0] fld;
      assign fld = young_ops[k*OPF_W +: OPF_W];
      assign hit[k] = old_dst[EN_BIT] && fld[EN_BIT] &&
                      (old_dst[FP_BIT] == fld[FP_BIT]) &&
                      (old_dst[RIDX_W-1:0] == fld[RIDX_W-1:0]);
    end
  endgenerate

  assign conflict = |hit;

  // R6
  dep_needs_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |-> old_dst[EN_BIT]);

  // R8
  dep_same_file_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conflict && $countones(hit) == 1 && hit[0])
      |-> (young_ops[FP_BIT] == old_dst[FP_BIT]));

endmodule

// File: rtl/dual_issue_pair.sv
`timescale 1ns/1ps
module dual_issue_pair
  import dual_pair_pkg::*;
#(
  parameter int RIDX_W = 5,
  localparam int OPF_W  = RIDX_W + 2,
  localparam int INSN_W = CLS_W + NUM_OPS * OPF_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic              slot0_valid,
  input  logic [INSN_W-1:0] slot0_insn,
  input  logic              slot1_valid,
  input  logic [INSN_W-1:0] slot1_insn,
  output logic              issue0,
  output logic              issue1,
  output logic              hold1
);

  logic mix_ok;
  logic dep_hit;

  pair_class_chk u_cls (
    .cls_old   (slot0_insn[CLS_W-1:0]),
    .cls_young (slot1_insn[CLS_W-1:0]),
    .mix_ok    (mix_ok)
  );

  pair_dep_chk #(.RIDX_W(RIDX_W)) u_dep (
    .clk       (clk),
    .rst_n     (rst_n),
    .old_dst   (slot0_insn[CLS_W +: OPF_W]),
    .young_ops (slot1_insn[INSN_W-1:CLS_W]),
    .conflict  (dep_hit)
  );

  always_comb begin
    issue0 = slot0_valid && !stall;
    issue1 = issue0 && slot1_valid && mix_ok && !dep_hit;
    hold1  = slot1_valid && !stall && !issue1;
  end

  // R3
  order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue1 |-> (issue0 && !$isunknown(slot0_insn)));

  // R2
  stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!issue0 && !issue1 && !hold1));

  // R9
  hold_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold1 |-> (slot1_valid && !issue1));

  // R1
  issue_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue0 |-> slot0_valid);

  // R5
  rsv_nopair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((slot0_insn[1:0] == CLS_RSV) || (slot1_insn[1:0] == CLS_RSV)) |-> !issue1);

  // R10
  lone_young_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot0_valid && slot1_valid && !stall) |-> (hold1 && !issue1));

endmodule

// File: tb/sim_dual_issue_pair.sv
`timescale 1ns/1ps
module sim_dual_issue_pair;

  localparam int RW     = 2;
  localparam int OPF    = RW + 2;
  localparam int IW     = 2 + 3 * OPF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stall = 1'b0;
  logic v0 = 1'b0, v1 = 1'b0;
  logic [IW-1:0] i0 = '0, i1 = '0;
  logic issue0, issue1, hold1;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dual_issue_pair #(.RIDX_W(RW)) u0 (
    .clk(clk), .rst_n(rst_n), .stall(stall),
    .slot0_valid(v0), .slot0_insn(i0),
    .slot1_valid(v1), .slot1_insn(i1),
    .issue0(issue0), .issue1(issue1), .hold1(hold1)
  );

  // word = {srcB, srcA, dst, class}; operand code = {en, fp, idx[1:0]}
  function automatic logic [IW-1:0] mk(input int cls, input int d, input int a, input int b);
    logic [3:0] dd, aa, bb;
    logic [1:0] cc;
    dd = 4'(d); aa = 4'(a); bb = 4'(b); cc = 2'(cls);
    return {bb, aa, dd, cc};
  endfunction

  function automatic bit clash(input int wr, input int rd);
    // both enabled (bit 3), same file (bit 2), same index (bits 1:0)
    return ((wr / 8) == 1) && ((rd / 8) == 1) && ((wr % 8) == (rd % 8));
  endfunction

  function automatic bit mixes(input int c0, input int c1);
    return (c0 == 2 && c1 < 2) || (c1 == 2 && c0 < 2);
  endfunction

  task automatic check(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic drive(input logic a_v, input logic [IW-1:0] a_i,
                       input logic b_v, input logic [IW-1:0] b_i, input logic st);
    @(negedge clk);
    v0 = a_v; i0 = a_i; v1 = b_v; i1 = b_i; stall = st;
    #1;
  endtask

  task automatic expect_all(input string tag, input bit e0, input bit e1, input bit eh);
    check({tag, " issue0"}, issue0, e0);
    check({tag, " issue1"}, issue1, e1);
    check({tag, " hold1"},  hold1,  eh);
  endtask

  initial begin
    #1;
    check("R1 reset issue0", issue0, 1'b0);
    check("R9 reset hold1", hold1, 1'b0);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R4 / R5: every class pairing, no operands enabled
    for (int c0 = 0; c0 < 4; c0++) begin
      for (int c1 = 0; c1 < 4; c1++) begin
        bit p;
        p = mixes(c0, c1);
        drive(1'b1, mk(c0, 0, 0, 0), 1'b1, mk(c1, 0, 0, 0), 1'b0);
        expect_all((c0 == 3 || c1 == 3) ? "R5 reserved" : (p ? "R4 mix" : "R5 same side"),
                   1'b1, p, !p);
      end
    end

    // R1 / R2 / R3 / R9 / R10: valid and stall combinations on a pairable pair
    for (int m = 0; m < 8; m++) begin
      bit a, b, s, e0, e1;
      a = m[0]; b = m[1]; s = m[2];
      e0 = a && !s;
      e1 = e0 && b;
      drive(a, mk(0, 9, 0, 0), b, mk(2, 13, 0, 0), s);
      if (s) expect_all("R2 stall", 1'b0, 1'b0, 1'b0);
      else if (!a) expect_all("R10 lone young", 1'b0, 1'b0, b);
      else expect_all("R3 R9 r1_ order", e0, e1, b && !e1);
    end

    // R6 / R7 / R8: slot 0 destination against each slot 1 operand, both class orders
    for (int ord = 0; ord < 2; ord++) begin
      for (int d = 0; d < 16; d++) begin
        for (int k = 0; k < 3; k++) begin
          for (int o = 0; o < 16; o++) begin
            bit hz;
            string tag;
            hz = clash(d, o);
            if (hz) tag = "R6 conflict";
            else if ((d / 8) == 0 || (o / 8) == 0) tag = "R7 disabled";
            else if ((d % 4) == (o % 4)) tag = "R8 other file";
            else tag = "R6 distinct";
            drive(1'b1, mk(ord == 0 ? 1 : 2, d, 0, 0), 1'b1,
                  mk(ord == 0 ? 2 : 0, k == 0 ? o : 0, k == 1 ? o : 0, k == 2 ? o : 0),
                  1'b0);
            check({tag, " issue1"}, issue1, !hz);
            check({tag, " hold1"},  hold1,  hz);
          end
        end
      end
    end

    // R6: several operands matching at once; R2: stall overrides a conflict
    drive(1'b1, mk(0, 10, 0, 0), 1'b1, mk(2, 10, 10, 10), 1'b0);
    expect_all("R6 multi-hit", 1'b1, 1'b0, 1'b1);
    drive(1'b1, mk(0, 10, 0, 0), 1'b1, mk(2, 10, 0, 0), 1'b1);
    expect_all("R2 stall with conflict", 1'b0, 1'b0, 1'b0);
    // R7: slot 0 writes nothing, slot 1 reuses its index bits
    drive(1'b1, mk(2, 6, 9, 9), 1'b1, mk(1, 14, 14, 14), 1'b0);
    expect_all("R7 no writer", 1'b1, 1'b1, 1'b0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule